// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable cycle-level model of a small dynamic memory. Its storage is a grid of supercells: 4 rows by 4 columns of 8-bit words, 16 supercells and 128 bits in all. Row and column indices share one narrow address bus at different times. Raising the row strobe opens a row: the row index is captured and the whole row is copied into an internal row buffer. While the row stays open, each column strobe picks one word of the buffer. A read returns that word on the data output one clock later. A write replaces that word in the buffer. Dropping the row strobe closes the row and writes the buffer back into the grid.

The model also tracks refresh for each row. Every row has an age counter. Opening a row counts as a refresh of that row. A row whose age reaches the programmed interval is flagged as stale. The interval is a parameter given in clock cycles. Its default is 10 ms at a 125 MHz clock, and any value from 10 ms to 100 ms worth of cycles may be chosen.

Top module: `dram_grid_model`

## Requirements
- R1: After reset, every supercell reads as zero, no row is open, `rdata`, `rdata_valid`, `col_err` are 0, and `stale_rows` is all zero.
- R2: A clock edge with `ras` high while no row is open opens the row given by `addr` and copies that row into the row buffer. While `ras` stays high, the open row does not change, whatever `addr` carries.
- R3: A clock edge with `ras` and `cas` high, `we` low and a row already open puts the buffer word at column `addr` on `rdata` with `rdata_valid` high after that edge. After any other edge, `rdata_valid` is 0 and `rdata` is 0.
- R4: A clock edge with `cas` high while `ras` is low, or while no row was open before that edge (including the edge that opens it), sets `col_err` for exactly one cycle. Such a column strobe returns no data, and if `we` is high it changes no stored word.
- R5: A clock edge with `ras`, `cas` and `we` high and a row open stores `wdata` into the buffer at column `addr`. Later reads in the same activation return the new word. A write never raises `rdata_valid`.
- R6: A clock edge with `ras` low while a row is open closes the row and writes the buffer back to it. The stored words survive later activations, and other rows are not affected.
- R7: Each row's bit in `stale_rows` rises exactly `REFRESH_CYCLES` clock edges after that row was last opened (or after reset). It stays high until the row is opened again, and the edge that opens the row clears it. `stale` is the OR of `stale_rows`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras | input | 1 | Row strobe; held high for as long as a row stays open |
| cas | input | 1 | Column strobe |
| we | input | 1 | Write select for a column strobe |
| addr | input | 2 | Shared row/column index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not valid |
| rdata_valid | output | 1 | Read data present on `rdata` |
| col_err | output | 1 | Column strobe arrived without an open row |
| stale_rows | output | 4 | One bit per row whose refresh interval has expired |
| stale | output | 1 | Any row stale |

## Verification
The hardest case to reach from the ports is the exact cycle on which a stale flag rises. Refresh ages advance on every clock edge, so every earlier access shifts the count. The bench first applies a fresh reset with a short interval and counts idle edges up to the boundary. It then opens one row and counts again from that activation. This shows that one row's flag clears and rises on its own while the other rows stay stale. Write-back is reached by writing into one row, closing it, visiting another row, and reopening the first.

// File: rtl/dram_grid_model.sv
module dram_grid_model #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int WIDTH = 8,
  parameter int REFRESH_CYCLES = 1250000,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras,
  input  logic              cas,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              rdata_valid,
  output logic              col_err,
  output logic [ROWS-1:0]   stale_rows,
  output logic              stale
);
  localparam int AGE_W = $clog2(REFRESH_CYCLES + 1);

  logic [WIDTH-1:0] cells   [ROWS][COLS];
  logic [WIDTH-1:0] row_buf [COLS];
  logic             row_open;
  logic [ROW_W-1:0] open_row;

  wire [ROW_W-1:0] row_sel   = addr[ROW_W-1:0];
  wire [COL_W-1:0] col_sel   = addr[COL_W-1:0];
  wire             activate  = ras & ~row_open;
  wire             precharge = ~ras & row_open;
  wire             col_ok    = cas & ras & row_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open    <= 1'b0;
      open_row    <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      col_err     <= 1'b0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++)
        row_buf[c] <= '0;
    end else begin
      rdata_valid <= col_ok & ~we;
      rdata       <= (col_ok & ~we) ? row_buf[col_sel] : '0;
      col_err     <= cas & ~(ras & row_open);
      if (activate) begin
        row_open <= 1'b1;
        open_row <= row_sel;
        for (int c = 0; c < COLS; c++)
          row_buf[c] <= cells[row_sel][c];
      end
      if (precharge) begin
        row_open <= 1'b0;
        for (int c = 0; c < COLS; c++)
          cells[open_row][c] <= row_buf[c];
      end
      if (col_ok && we)
        row_buf[col_sel] <= wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)
        age <= '0;
      else if (activate && row_sel == ROW_W'(r))
        age <= '0;
      else if (age != AGE_W'(REFRESH_CYCLES))
        age <= age + 1'b1;
    end
    assign stale_rows[r] = (age == AGE_W'(REFRESH_CYCLES));
  end

  assign stale = |stale_rows;
endmodule

module dram_grid_model_chk #(
  parameter int ROWS = 4,
  parameter int WIDTH = 8,
  parameter int ROW_W = 2,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras,
  input logic              cas,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              row_open,
  input logic [ROW_W-1:0]  open_row,
  input logic [WIDTH-1:0]  rdata,
  input logic              rdata_valid,
  input logic              col_err,
  input logic [ROWS-1:0]   stale_rows
);
  assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_valid |-> rdata == '0);

  assert_read_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras && cas && !we && row_open) |=> (rdata_valid && !col_err));

  assert_row_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras && row_open) |=> (row_open && $stable(open_row)));

  assert_orphan_column_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas && !(ras && row_open)) |=> (col_err && !rdata_valid));

  assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas && we) |=> !rdata_valid);

  assert_close_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras && row_open) |=> !row_open);

  assert_refresh_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras && !row_open) |=> !stale_rows[open_row]);

  for (genvar r = 0; r < ROWS; r++) begin : g_hold
    assert_stale_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stale_rows[r] && !(ras && !row_open && addr[ROW_W-1:0] == ROW_W'(r)))
        |=> stale_rows[r]);
  end
endmodule

bind dram_grid_model dram_grid_model_chk #(
  .ROWS(ROWS), .WIDTH(WIDTH), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we), .addr(addr),
  .row_open(row_open), .open_row(open_row), .rdata(rdata),
  .rdata_valid(rdata_valid), .col_err(col_err), .stale_rows(stale_rows)
);

// File: tb/dram_grid_model_tb_top.sv
module dram_grid_model_tb_top;
  localparam int LIMIT = 40;
  localparam int NV = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras = 1'b0, cas = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_valid, col_err, stale;
  logic [3:0] stale_rows;

  int applied = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dram_grid_model #(.REFRESH_CYCLES(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
    .col_err(col_err), .stale_rows(stale_rows), .stale(stale)
  );

  // ras cas we addr wdata | valid err rdata
  localparam logic [22:0] VEC [NV] = '{
    {3'b100, 2'd1, 8'h00, 2'b00, 8'h00},  // R2 open row 1
    {3'b111, 2'd2, 8'hA5, 2'b00, 8'h00},  // R5 write col 2
    {3'b111, 2'd0, 8'h3C, 2'b00, 8'h00},  // R5 write col 0
    {3'b110, 2'd2, 8'h00, 2'b10, 8'hA5},  // R5 read back
    {3'b110, 2'd0, 8'h00, 2'b10, 8'h3C},  // R3
    {3'b110, 2'd3, 8'h00, 2'b10, 8'h00},  // R3
    {3'b000, 2'd0, 8'h00, 2'b00, 8'h00},  // R6 close
    {3'b100, 2'd2, 8'h00, 2'b00, 8'h00},  // R2 open row 2
    {3'b110, 2'd2, 8'h00, 2'b10, 8'h00},  // R6 other row untouched
    {3'b111, 2'd1, 8'h5A, 2'b00, 8'h00},  // R5
    {3'b000, 2'd0, 8'h00, 2'b00, 8'h00},  // R6
    {3'b100, 2'd1, 8'h00, 2'b00, 8'h00},  // reopen row 1
    {3'b110, 2'd2, 8'h00, 2'b10, 8'hA5},  // R6 written back
    {3'b110, 2'd0, 8'h00, 2'b10, 8'h3C},  // R6
    {3'b100, 2'd3, 8'h00, 2'b00, 8'h00},  // R2 addr ignored while open
    {3'b110, 2'd2, 8'h00, 2'b10, 8'hA5},  // R2 still row 1
    {3'b010, 2'd2, 8'h00, 2'b01, 8'h00},  // R4 cas with ras low
    {3'b100, 2'd2, 8'h00, 2'b00, 8'h00},  // open row 2
    {3'b110, 2'd1, 8'h00, 2'b10, 8'h5A},  // R6
    {3'b000, 2'd0, 8'h00, 2'b00, 8'h00},
    {3'b011, 2'd1, 8'hFF, 2'b01, 8'h00},  // R4 orphan write
    {3'b100, 2'd2, 8'h00, 2'b00, 8'h00},
    {3'b110, 2'd1, 8'h00, 2'b10, 8'h5A},  // R4 write had no effect
    {3'b000, 2'd0, 8'h00, 2'b00, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic c, input logic w,
                     input logic [1:0] a, input logic [7:0] d);
    ras = r; cas = c; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ras = 0; cas = 0; we = 0; addr = 0; wdata = 0;
    @(posedge clk); @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 rdata", {24'd0, rdata}, 32'd0);
    check("R1 valid/err", {30'd0, rdata_valid, col_err}, 32'd0);
    check("R1 stale_rows", {28'd0, stale_rows}, 32'd0);
    check("R1 stale", {31'd0, stale}, 32'd0);
    cyc(1, 0, 0, 2'd3, 8'h00);
    for (int c = 0; c < 4; c++) begin
      cyc(1, 1, 0, 2'(c), 8'h00);
      check("R1 zero cell", {23'd0, rdata_valid, rdata}, {23'd0, 1'b1, 8'h00});
    end
    cyc(0, 0, 0, 2'd0, 8'h00);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:18], VEC[i][17:10]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i),
            {22'd0, rdata_valid, col_err, rdata}, {22'd0, VEC[i][9:0]});
    end

    // R4 cas on the activating edge, error lasts one cycle
    cyc(1, 1, 0, 2'd0, 8'h00);
    check("R4 same-edge cas", {30'd0, col_err, rdata_valid}, 32'd2);
    cyc(1, 0, 0, 2'd0, 8'h00);
    check("R4 single pulse", {31'd0, col_err}, 32'd0);
    cyc(0, 0, 0, 2'd0, 8'h00);

    // R7 stale timing from reset and from an activation
    do_reset();
    for (int k = 0; k < LIMIT - 1; k++) cyc(0, 0, 0, 2'd0, 8'h00);
    check("R7 before expiry", {28'd0, stale_rows}, 32'h0);
    cyc(0, 0, 0, 2'd0, 8'h00);
    check("R7 at expiry", {28'd0, stale_rows}, 32'hF);
    check("R7 stale or", {31'd0, stale}, 32'd1);
    cyc(1, 0, 0, 2'd2, 8'h00);
    check("R7 refresh clears row", {28'd0, stale_rows}, 32'hB);
    cyc(0, 0, 0, 2'd0, 8'h00);
    for (int k = 0; k < LIMIT - 2; k++) cyc(0, 0, 0, 2'd0, 8'h00);
    check("R7 refreshed row fresh", {28'd0, stale_rows}, 32'hB);
    cyc(0, 0, 0, 2'd0, 8'h00);
    check("R7 refreshed row expires", {28'd0, stale_rows}, 32'hF);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule